// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small translation buffer that software fills and manages entirely on its own. Each entry maps one 4 KB virtual page to a physical frame. Each entry also carries a context tag that names the address space it belongs to. A running-context register selects the active address space. Entries belonging to other address spaces stay resident but do not match, so a context switch needs no flush.

Software reaches the entries through a single word-wide register port. It first loads an entry index into a select register. It then reads or writes that entry's tag word (virtual page and context) and its mapping word (physical frame and attribute flags). One context value is reserved and can never become the running context. Software retires an entry by tagging it with that value.

A separate lookup port takes a virtual address together with a user/kernel indication and a write indication. Within the same cycle it returns a hit flag, the physical frame and a fault code. The block does no table walking and no refill: a miss is simply reported.

Top module: `ctx_tlb`

## Requirements
- R1: After reset, every entry reads back with context 63, virtual page 0, physical frame 0 and all flags clear. The running context reads 0 and the select register reads 0.
- R2: A lookup hits when the entry's virtual page equals VA[31:12] and either the entry's context equals the running context or the entry's global flag is set. On a hit, the entry's physical frame is driven on `lk_pfn_o`.
- R3: A register write that tries to load 63 into the running context is ignored, and the running context keeps its previous value. An entry tagged with context 63 and with global clear never hits.
- R4: The register addresses are 0 = select (index in bits 5:0), 1 = tag word, 2 = mapping word and 3 = running context (bits 5:0). The tag word holds the virtual page in bits 31:12 and the context in bits 5:0. The mapping word holds the frame in bits 31:12, global in bit 3, valid in bit 2, kernel-only in bit 1 and write-enable in bit 0. Unused bits read as 0. `reg_rdata_o` shows the addressed register combinationally, and for the tag and mapping words it shows the entry picked by the select register.
- R5: Entry index i belongs to set i[5:2] and way i[1:0]. A lookup searches only the set VA[15:12]. If several ways match, the lowest-numbered way supplies the result.
- R6: The fault code is 0 = none, 1 = invalid, 2 = protection, 3 = write. A hit on an entry with valid clear gives 1. Otherwise, a user-mode access to a kernel-only entry gives 2. Otherwise, a write to an entry with write-enable clear gives 3. Otherwise the code is 0.
- R7: On a miss, `lk_hit_o`, `lk_pfn_o` and `lk_fault_o` are all 0.
- R8: The lookup is combinational. A register write changes lookups and readback from the next cycle on, and not in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_user_i | input | 1 | Lookup is a user-mode access |
| lk_write_i | input | 1 | Lookup is a write access |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | 20 | Physical frame on a hit |
| lk_fault_o | output | 2 | Fault code |

## Verification
The directed patterns are run first. A sweep of all 64 entries after reset separates correct reset loading from a mis-decoded select index. A single entry whose lookup coincides with its own programming shows whether the update waits one cycle. Two entries with the same page in the same set, placed in ways 1 and 3, show whether the lowest-way rule is kept. Lookups against a foreign-context entry, first with global clear and then with global set, separate tag matching from the global override. A walk through the flag combinations separates the three fault priorities. After that, a long random mix of writes and lookups runs over a small pool of page numbers and contexts, including the reserved one. Because the pool is small, set collisions, context switches and attempts to load context 63 occur often, and every cycle is compared against a behavioural model.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  localparam int VA_W    = 32;
  localparam int PAGE_W  = 12;
  localparam int CTX_W   = 6;
  localparam int PFN_W   = 20;
  localparam int SETS    = 16;
  localparam int WAYS    = 4;
  localparam int VPN_W   = VA_W - PAGE_W;
  localparam int ENTRIES = SETS * WAYS;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int IDX_W   = SET_W + WAY_W;

  localparam logic [CTX_W-1:0] CTX_PARKED = '1;

  // mapping-word flag positions
  localparam int LO_WEN  = 0;
  localparam int LO_KERN = 1;
  localparam int LO_VAL  = 2;
  localparam int LO_GLOB = 3;

  typedef enum logic [1:0] {
    REG_SEL = 2'd0,
    REG_TAG = 2'd1,
    REG_MAP = 2'd2,
    REG_CTX = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_INVAL = 2'd1,
    FLT_PROT  = 2'd2,
    FLT_WRITE = 2'd3
  } fault_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [CTX_W-1:0] ctx;
    logic [PFN_W-1:0] pfn;
    logic             glob;
    logic             valid;
    logic             kern;
    logic             wen;
  } entry_t;

  localparam entry_t ENTRY_RST = '{vpn: '0, ctx: CTX_PARKED, pfn: '0,
                                   glob: 1'b0, valid: 1'b0, kern: 1'b0, wen: 1'b0};
endpackage

// File: rtl/tlb_regfile.sv
module tlb_regfile
  import ctx_tlb_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  reg_addr_e                 addr_i,
  input  logic [VA_W-1:0]           wdata_i,
  output logic [VA_W-1:0]           rdata_o,
  output entry_t [ENTRIES-1:0]      entries_o,
  output logic [CTX_W-1:0]          run_ctx_o
);
  entry_t [ENTRIES-1:0] ent_q;
  logic [IDX_W-1:0]     sel_q;
  logic [CTX_W-1:0]     ctx_q;
  entry_t               cur;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[PAGE_W-1:CTX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      ctx_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ENTRY_RST;
    end else if (we_i) begin
      unique case (addr_i)
        REG_SEL: sel_q <= wdata_i[IDX_W-1:0];
        REG_TAG: begin
          ent_q[sel_q].vpn <= wdata_i[VA_W-1:PAGE_W];
          ent_q[sel_q].ctx <= wdata_i[CTX_W-1:0];
        end
        REG_MAP: begin
          ent_q[sel_q].pfn   <= wdata_i[VA_W-1:PAGE_W];
          ent_q[sel_q].glob  <= wdata_i[LO_GLOB];
          ent_q[sel_q].valid <= wdata_i[LO_VAL];
          ent_q[sel_q].kern  <= wdata_i[LO_KERN];
          ent_q[sel_q].wen   <= wdata_i[LO_WEN];
        end
        REG_CTX: if (wdata_i[CTX_W-1:0] != CTX_PARKED) ctx_q <= wdata_i[CTX_W-1:0];
        default: ;
      endcase
    end
  end

  assign cur = ent_q[sel_q];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_SEL: rdata_o[IDX_W-1:0] = sel_q;
      REG_TAG: begin
        rdata_o[VA_W-1:PAGE_W] = cur.vpn;
        rdata_o[CTX_W-1:0]     = cur.ctx;
      end
      REG_MAP: begin
        rdata_o[VA_W-1:PAGE_W] = cur.pfn;
        rdata_o[LO_GLOB]       = cur.glob;
        rdata_o[LO_VAL]        = cur.valid;
        rdata_o[LO_KERN]       = cur.kern;
        rdata_o[LO_WEN]        = cur.wen;
      end
      REG_CTX: rdata_o[CTX_W-1:0] = ctx_q;
      default: ;
    endcase
  end

  assign entries_o = ent_q;
  assign run_ctx_o = ctx_q;

  p_ctx_runnable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_q != CTX_PARKED);

  p_parked_ctx_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CTX && wdata_i[CTX_W-1:0] == CTX_PARKED) |=> $stable(ctx_q));

  p_tag_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_TAG) |=>
      ent_q[$past(sel_q)].vpn == $past(wdata_i[VA_W-1:PAGE_W]));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import ctx_tlb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  entry_t [ENTRIES-1:0] entries_i,
  input  logic [CTX_W-1:0]     run_ctx_i,
  input  logic [VPN_W-1:0]     vpn_i,
  output logic                 hit_o,
  output entry_t               ent_o
);
  logic [SET_W-1:0] set_idx;
  entry_t [WAYS-1:0] way_ent;
  logic [WAYS-1:0]  match;
  logic [WAYS-1:0]  grant;

  assign set_idx = vpn_i[SET_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    assign way_ent[w] = entries_i[{set_idx, WI}];
    assign match[w]   = (way_ent[w].vpn == vpn_i) &&
                        (way_ent[w].glob || way_ent[w].ctx == run_ctx_i);
  end

  // lowest way wins
  always_comb begin
    grant = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        grant    = '0;
        grant[w] = 1'b1;
      end
    end
  end

  always_comb begin
    ent_o = '0;
    for (int w = 0; w < WAYS; w++) if (grant[w]) ent_o = way_ent[w];
  end

  assign hit_o = |match;

  p_grant_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~match) == '0));

  p_grant_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (grant != '0));
endmodule

// File: rtl/tlb_check.sv
module tlb_check
  import ctx_tlb_pkg::*;
(
  input  logic             hit_i,
  input  entry_t           ent_i,
  input  logic             user_i,
  input  logic             write_i,
  output logic [PFN_W-1:0] pfn_o,
  output fault_e           fault_o
);
  always_comb begin
    pfn_o   = '0;
    fault_o = FLT_NONE;
    if (hit_i) begin
      pfn_o = ent_i.pfn;
      if (!ent_i.valid)                fault_o = FLT_INVAL;
      else if (user_i && ent_i.kern)   fault_o = FLT_PROT;
      else if (write_i && !ent_i.wen)  fault_o = FLT_WRITE;
    end
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [31:0]      lk_va_i,
  input  logic             lk_user_i,
  input  logic             lk_write_i,
  output logic             lk_hit_o,
  output logic [19:0]      lk_pfn_o,
  output logic [1:0]       lk_fault_o
);
  entry_t [ENTRIES-1:0] entries;
  logic [CTX_W-1:0]     run_ctx;
  entry_t               sel_ent;
  fault_e               fault;
  logic [VPN_W-1:0]     vpn;

  logic unused_offset;
  assign unused_offset = ^lk_va_i[PAGE_W-1:0];
  assign vpn = lk_va_i[VA_W-1:PAGE_W];

  tlb_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_e'(reg_addr_i)),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .entries_o (entries),
    .run_ctx_o (run_ctx)
  );

  tlb_match u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .entries_i (entries),
    .run_ctx_i (run_ctx),
    .vpn_i     (vpn),
    .hit_o     (lk_hit_o),
    .ent_o     (sel_ent)
  );

  tlb_check u_check (
    .hit_i   (lk_hit_o),
    .ent_i   (sel_ent),
    .user_i  (lk_user_i),
    .write_i (lk_write_i),
    .pfn_o   (lk_pfn_o),
    .fault_o (fault)
  );

  assign lk_fault_o = fault;

  p_hit_tag_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (sel_ent.vpn == vpn) && (sel_ent.glob || sel_ent.ctx == run_ctx));

  p_parked_never_hits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (sel_ent.glob || sel_ent.ctx != CTX_PARKED));

  p_miss_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_fault_o == 2'd0) && (lk_pfn_o == '0));
endmodule

// File: tb/ctx_tlb_bench.sv
`timescale 1ns/1ps
module ctx_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] lk_va = '0;
  logic        lk_user = 1'b0;
  logic        lk_write = 1'b0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic [1:0]  lk_fault;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [19:0] m_vpn [64];
  logic [5:0]  m_ctx [64];
  logic [19:0] m_pfn [64];
  logic [3:0]  m_flg [64]; // {glob, valid, kern, wen}
  logic [5:0]  m_sel;
  logic [5:0]  m_run;

  always #2.5 clk = ~clk;

  ctx_tlb u_ctx_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .lk_va_i(lk_va), .lk_user_i(lk_user), .lk_write_i(lk_write),
    .lk_hit_o(lk_hit), .lk_pfn_o(lk_pfn), .lk_fault_o(lk_fault)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin
      m_vpn[i] = '0; m_ctx[i] = 6'd63; m_pfn[i] = '0; m_flg[i] = '0;
    end
    m_sel = '0; m_run = '0;
  endtask

  // drive one cycle, compare combinational outputs, then commit the write
  task automatic step(input string tag, input bit we, input logic [1:0] a, input logic [31:0] d,
                      input logic [31:0] va, input bit user, input bit wr);
    bit          e_hit;
    logic [19:0] e_pfn;
    logic [1:0]  e_flt;
    logic [31:0] e_rd;
    int          s;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; lk_va = va; lk_user = user; lk_write = wr;
    #1;
    e_hit = 1'b0; e_pfn = '0; e_flt = 2'd0;
    s = int'(va[15:12]);
    for (int w = 0; w < 4; w++) begin
      int i;
      i = s * 4 + w;
      if (!e_hit && m_vpn[i] == va[31:12] && (m_flg[i][3] || m_ctx[i] == m_run)) begin
        e_hit = 1'b1;
        e_pfn = m_pfn[i];
        if (!m_flg[i][2])                 e_flt = 2'd1;
        else if (user && m_flg[i][1])     e_flt = 2'd2;
        else if (wr && !m_flg[i][0])      e_flt = 2'd3;
      end
    end
    case (a)
      2'd0: e_rd = {26'b0, m_sel};
      2'd1: e_rd = {m_vpn[m_sel], 6'b0, m_ctx[m_sel]};
      2'd2: e_rd = {m_pfn[m_sel], 8'b0, m_flg[m_sel]};
      default: e_rd = {26'b0, m_run};
    endcase
    chk(tag, "hit", {31'b0, lk_hit}, {31'b0, e_hit});
    chk(tag, "pfn", {12'b0, lk_pfn}, {12'b0, e_pfn});
    chk(tag, "fault", {30'b0, lk_fault}, {30'b0, e_flt});
    chk(tag, "rdata", reg_rdata, e_rd);
    if (we) begin
      case (a)
        2'd0: m_sel = d[5:0];
        2'd1: begin m_vpn[m_sel] = d[31:12]; m_ctx[m_sel] = d[5:0]; end
        2'd2: begin m_pfn[m_sel] = d[31:12]; m_flg[m_sel] = d[3:0]; end
        default: if (d[5:0] != 6'd63) m_run = d[5:0];
      endcase
    end
  endtask

  task automatic wr_reg(input string tag, input logic [1:0] a, input logic [31:0] d);
    step(tag, 1'b1, a, d, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic load(input string tag, input int idx, input logic [19:0] vpn, input logic [5:0] ctx,
                      input logic [19:0] pfn, input logic [3:0] flg);
    wr_reg(tag, 2'd0, 32'(idx));
    wr_reg(tag, 2'd1, {vpn, 6'b0, ctx});
    wr_reg(tag, 2'd2, {pfn, 8'b0, flg});
  endtask

  task automatic look(input string tag, input logic [19:0] vpn, input bit user, input bit wr);
    step(tag, 1'b0, 2'd3, 32'h0, {vpn, 12'h5a5}, user, wr);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents through every index
    step("R1", 1'b0, 2'd3, 32'h0, 32'h0, 1'b0, 1'b0);
    step("R1", 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0);
    for (int i = 0; i < 64; i++) begin
      wr_reg("R1", 2'd0, 32'(i));
      step("R1", 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 1'b0);
      step("R1", 1'b0, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
    end

    // R4/R8: index 5 = set 1 way 1; lookup in the cycle of the mapping write still sees old state
    wr_reg("R4", 2'd0, 32'd5);
    wr_reg("R4", 2'd1, {20'h00011, 6'b0, 6'd0});
    step("R8", 1'b1, 2'd2, {20'hABCDE, 8'b0, 4'b0110}, {20'h00011, 12'h0}, 1'b0, 1'b0);
    look("R8", 20'h00011, 1'b0, 1'b0);
    look("R2", 20'h00011, 1'b0, 1'b1);
    step("R4", 1'b0, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0);
    look("R7", 20'h00021, 1'b0, 1'b0);

    // R6: fault priorities
    look("R6", 20'h00011, 1'b1, 1'b0);
    load("R6", 5, 20'h00011, 6'd0, 20'hABCDE, 4'b0111);
    look("R6", 20'h00011, 1'b1, 1'b1);
    look("R6", 20'h00011, 1'b0, 1'b1);
    load("R6", 5, 20'h00011, 6'd0, 20'hABCDE, 4'b0100);
    look("R6", 20'h00011, 1'b0, 1'b1);
    look("R6", 20'h00011, 1'b1, 1'b0);
    load("R6", 5, 20'h00011, 6'd0, 20'hABCDE, 4'b0010);
    look("R6", 20'h00011, 1'b1, 1'b1);

    // R5: same page in ways 3 and 1 of set 2
    load("R5", 11, 20'h00042, 6'd0, 20'h33333, 4'b0101);
    load("R5", 9,  20'h00042, 6'd0, 20'h11111, 4'b0101);
    look("R5", 20'h00042, 1'b0, 1'b0);
    load("R5", 9,  20'h00042, 6'd63, 20'h11111, 4'b0101);
    look("R5", 20'h00042, 1'b0, 1'b0);

    // R2: foreign context, then global override
    load("R2", 12, 20'h00073, 6'd4, 20'h77777, 4'b0101);
    look("R2", 20'h00073, 1'b0, 1'b0);
    wr_reg("R2", 2'd3, 32'd4);
    look("R2", 20'h00073, 1'b0, 1'b0);
    wr_reg("R2", 2'd3, 32'd1);
    load("R2", 12, 20'h00073, 6'd4, 20'h77777, 4'b1101);
    look("R2", 20'h00073, 1'b0, 1'b0);

    // R3: parked context cannot be loaded and never hits
    wr_reg("R3", 2'd3, 32'd63);
    step("R3", 1'b0, 2'd3, 32'h0, 32'h0, 1'b0, 1'b0);
    load("R3", 20, 20'h00085, 6'd63, 20'h88888, 4'b0101);
    look("R3", 20'h00085, 1'b0, 1'b0);

    // randomized mix against the model
    for (int n = 0; n < 6000; n++) begin
      int op;
      logic [19:0] v;
      logic [5:0]  c;
      op = int'($urandom_range(0, 9));
      v  = 20'($urandom_range(0, 47));
      c  = ($urandom_range(0, 7) == 0) ? 6'd63 : 6'($urandom_range(0, 3));
      case (op)
        0: wr_reg("R4", 2'd0, 32'($urandom_range(0, 63)));
        1: wr_reg("R4", 2'd1, {v, 6'b0, c});
        2: wr_reg("R4", 2'd2, {20'($urandom), 8'b0, 4'($urandom)});
        3: wr_reg("R3", 2'd3, {26'b0, c});
        4: step("R4", 1'b0, 2'($urandom_range(0, 3)), 32'h0, {v, 12'h0}, 1'b0, 1'b0);
        default: step("R2", 1'b0, 2'd3, 32'h0, {v, 12'($urandom)}, 1'($urandom), 1'($urandom));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule